// File: doc/BRIEF.md
# Store-Data Forwarding and Load-Use Stall Control

This block is the hazard-control logic for a five-stage load/store pipeline. It reads the register-number, register-write and memory-access fields held in the decode, execute, memory and write-back pipeline registers. From them it produces three things:

- the operand selects and forwarded operands for the execute stage;
- the data a store sends to memory;
- the control that holds the front of the pipeline for one cycle when a hazard cannot be covered by forwarding.

The distinguishing feature is a forwarding path from write-back into the memory stage. When a load is followed at once by a store of the register that load writes, the loaded value reaches the store in its memory stage, so no bubble is needed. The stall rule is narrowed to match. Only a decode-stage instruction that needs the loaded register as an ALU operand is held. An instruction that needs it only as store data is not held.

The block is purely combinational and sits beside the pipeline registers. Every input is a stage field and every output is consumed in the same cycle. There is no data stream at its edge, so it has no valid/ready handshake and no back-pressure rules. The pipeline must honour the stall outputs.

Top module: `ldst_fwd_ctrl`

## Requirements
- R1: When the memory-stage instruction is a store (`exmem_mem_wr`=1), write-back writes a register (`memwb_reg_wr`=1), `memwb_rd` is not 0, and `memwb_rd` equals `exmem_rs2`, then `store_sel`=1 and `store_data` equals `memwb_wdata`.
- R2: In every other case `store_sel`=0 and `store_data` equals `exmem_store_data`. This includes a write-back destination of register 0.
- R3: An execute operand select of 2'b10 (memory stage) is produced when `exmem_reg_wr`=1, `exmem_mem_rd`=0, `exmem_rd` is not 0 and `exmem_rd` matches the operand's source register. The operand then equals `exmem_alu`. A load in the memory stage never forwards from there.
- R4: An execute operand select of 2'b01 (write-back) is produced when the memory stage does not forward, `memwb_reg_wr`=1, `memwb_rd` is not 0 and `memwb_rd` matches the source. The operand then equals `memwb_wdata`.
- R5: When the memory stage and write-back both match the same source, the memory stage wins with select 2'b10.
- R6: With no forward, the select is 2'b00 and the operand is the register-file value. A destination of register 0 never forwards.
- R7: `stall`=1 when `idex_mem_rd`=1, `idex_rd` is not 0, and the decode-stage instruction uses `idex_rd` as an ALU source (`ifid_rs1` with `ifid_rs1_alu`=1, or `ifid_rs2` with `ifid_rs2_alu`=1).
- R8: A decode-stage instruction that reads the loaded register only as store data (its ALU-use flag is 0) causes no stall. A load followed by a store of the loaded register flows with zero bubbles.
- R9: While `stall`=1, `pc_wr_en`=0, `ifid_wr_en`=0 and `idex_bubble`=1. Otherwise the three are 1, 1 and 0.
- R10: A load whose destination is register 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs1 | input | REG_AW | First source register of the execute-stage instruction |
| idex_rs2 | input | REG_AW | Second source register of the execute-stage instruction |
| idex_rd | input | REG_AW | Destination of the execute-stage instruction |
| idex_mem_rd | input | 1 | Execute-stage instruction is a load |
| idex_rs1_val | input | DATA_W | Register-file value for the first source |
| idex_rs2_val | input | DATA_W | Register-file value for the second source |
| exmem_rd | input | REG_AW | Destination of the memory-stage instruction |
| exmem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| exmem_mem_rd | input | 1 | Memory-stage instruction is a load |
| exmem_mem_wr | input | 1 | Memory-stage instruction is a store |
| exmem_rs2 | input | REG_AW | Store-data source register of the memory-stage instruction |
| exmem_alu | input | DATA_W | ALU result held in the memory stage |
| exmem_store_data | input | DATA_W | Store data carried into the memory stage |
| memwb_rd | input | REG_AW | Destination of the write-back instruction |
| memwb_reg_wr | input | 1 | Write-back instruction writes a register |
| memwb_wdata | input | DATA_W | Value being written back |
| ifid_rs1 | input | REG_AW | First source of the decode-stage instruction |
| ifid_rs2 | input | REG_AW | Second source of the decode-stage instruction |
| ifid_rs1_alu | input | 1 | Decode-stage instruction uses its first source in the ALU |
| ifid_rs2_alu | input | 1 | Decode-stage instruction uses its second source in the ALU |
| fwd_a_sel | output | 2 | First operand select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_sel | output | 2 | Second operand select, same encoding |
| ex_opa | output | DATA_W | Forwarded first execute operand |
| ex_opb | output | DATA_W | Forwarded second execute operand |
| store_sel | output | 1 | 1 when store data is taken from write-back |
| store_data | output | DATA_W | Data sent to memory by the store |
| stall | output | 1 | Load-use hazard detected |
| pc_wr_en | output | 1 | PC may advance |
| ifid_wr_en | output | 1 | Decode register may load |
| idex_bubble | output | 1 | Clear control bits entering execute |

## Verification
The bench builds the block with its default values: 5-bit register numbers and 32-bit data. Register 0 and register 31 are therefore both reachable, and the register-0 exclusion can be tested on every path. A small pipeline model in the bench runs these instruction sequences and counts stall cycles:

- a three-word copy made of load/store pairs;
- a load followed by a dependent ALU operation;
- the same sequence with an independent load moved in between;
- loads to register 0.

Directed cases then set stage fields directly to exercise forwarding priority and the exclusion of a load from memory-stage forwarding.

// File: rtl/ldst_fwd_pkg.sv
package ldst_fwd_pkg;
  // Execute operand source encoding
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } ex_src_e;
endpackage

// File: rtl/ex_fwd_unit.sv
module ex_fwd_unit
  import ldst_fwd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] src,
  input  logic              mem_reg_wr,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              wb_reg_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output ex_src_e           sel,
  output logic [DATA_W-1:0] val
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;

  // A load in the memory stage has no data yet; never forward from there.
  assign mem_hit = mem_reg_wr && !mem_is_load && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_reg_wr && (wb_rd != ZERO_REG) && (wb_rd == src);

  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_MEM: val = mem_val;
      SRC_WB:  val = wb_val;
      default: val = rf_val;
    endcase
  end
endmodule

// File: rtl/mem_store_fwd.sv
module mem_store_fwd #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              is_store,
  input  logic [REG_AW-1:0] store_src,
  input  logic [DATA_W-1:0] carried_data,
  input  logic              wb_reg_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic [DATA_W-1:0] wb_val,
  output logic              use_wb,
  output logic [DATA_W-1:0] data_out
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  assign use_wb   = is_store && wb_reg_wr && (wb_rd != ZERO_REG) && (wb_rd == store_src);
  assign data_out = use_wb ? wb_val : carried_data;
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW = 5
) (
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic              dec_rs1_alu,
  input  logic              dec_rs2_alu,
  output logic              hold,
  output logic              pc_en,
  output logic              dec_en,
  output logic              bubble
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic rs1_dep, rs2_dep;

  // Only ALU uses need the value in execute; store data is covered later.
  assign rs1_dep = dec_rs1_alu && (dec_rs1 == ex_rd);
  assign rs2_dep = dec_rs2_alu && (dec_rs2 == ex_rd);
  assign hold    = ex_is_load && (ex_rd != ZERO_REG) && (rs1_dep || rs2_dep);

  assign pc_en  = !hold;
  assign dec_en = !hold;
  assign bubble = hold;
endmodule

// File: rtl/ldst_fwd_ctrl.sv
module ldst_fwd_ctrl
  import ldst_fwd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] idex_rs1,
  input  logic [REG_AW-1:0] idex_rs2,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_mem_rd,
  input  logic [DATA_W-1:0] idex_rs1_val,
  input  logic [DATA_W-1:0] idex_rs2_val,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_reg_wr,
  input  logic              exmem_mem_rd,
  input  logic              exmem_mem_wr,
  input  logic [REG_AW-1:0] exmem_rs2,
  input  logic [DATA_W-1:0] exmem_alu,
  input  logic [DATA_W-1:0] exmem_store_data,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_reg_wr,
  input  logic [DATA_W-1:0] memwb_wdata,
  input  logic [REG_AW-1:0] ifid_rs1,
  input  logic [REG_AW-1:0] ifid_rs2,
  input  logic              ifid_rs1_alu,
  input  logic              ifid_rs2_alu,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic [DATA_W-1:0] ex_opa,
  output logic [DATA_W-1:0] ex_opb,
  output logic              store_sel,
  output logic [DATA_W-1:0] store_data,
  output logic              stall,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              idex_bubble
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][REG_AW-1:0] op_src;
  logic [N_OPS-1:0][DATA_W-1:0] op_rf;
  logic [N_OPS-1:0][DATA_W-1:0] op_val;
  ex_src_e                      op_sel [N_OPS];

  assign op_src = {idex_rs2, idex_rs1};
  assign op_rf  = {idex_rs2_val, idex_rs1_val};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    ex_fwd_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_fwd (
      .src        (op_src[g]),
      .mem_reg_wr (exmem_reg_wr),
      .mem_is_load(exmem_mem_rd),
      .mem_rd     (exmem_rd),
      .wb_reg_wr  (memwb_reg_wr),
      .wb_rd      (memwb_rd),
      .rf_val     (op_rf[g]),
      .mem_val    (exmem_alu),
      .wb_val     (memwb_wdata),
      .sel        (op_sel[g]),
      .val        (op_val[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];
  assign ex_opa    = op_val[0];
  assign ex_opb    = op_val[1];

  mem_store_fwd #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_store (
    .is_store    (exmem_mem_wr),
    .store_src   (exmem_rs2),
    .carried_data(exmem_store_data),
    .wb_reg_wr   (memwb_reg_wr),
    .wb_rd       (memwb_rd),
    .wb_val      (memwb_wdata),
    .use_wb      (store_sel),
    .data_out    (store_data)
  );

  load_use_detect #(.REG_AW(REG_AW)) u_hzd (
    .ex_is_load (idex_mem_rd),
    .ex_rd      (idex_rd),
    .dec_rs1    (ifid_rs1),
    .dec_rs2    (ifid_rs2),
    .dec_rs1_alu(ifid_rs1_alu),
    .dec_rs2_alu(ifid_rs2_alu),
    .hold       (stall),
    .pc_en      (pc_wr_en),
    .dec_en     (ifid_wr_en),
    .bubble     (idex_bubble)
  );
endmodule

// File: rtl/ldst_fwd_ctrl_chk.sv
module ldst_fwd_ctrl_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_AW-1:0] idex_rs1,
  input logic [REG_AW-1:0] idex_rd,
  input logic              idex_mem_rd,
  input logic [DATA_W-1:0] idex_rs1_val,
  input logic [REG_AW-1:0] exmem_rd,
  input logic              exmem_mem_rd,
  input logic              exmem_mem_wr,
  input logic [DATA_W-1:0] exmem_alu,
  input logic [DATA_W-1:0] exmem_store_data,
  input logic [REG_AW-1:0] memwb_rd,
  input logic              memwb_reg_wr,
  input logic [DATA_W-1:0] memwb_wdata,
  input logic [1:0]        fwd_a_sel,
  input logic [1:0]        fwd_b_sel,
  input logic [DATA_W-1:0] ex_opa,
  input logic              store_sel,
  input logic [DATA_W-1:0] store_data,
  input logic              stall,
  input logic              pc_wr_en,
  input logic              ifid_wr_en,
  input logic              idex_bubble
);
  always_comb begin
    a_r1_store_from_wb: assert (!store_sel || (exmem_mem_wr && memwb_reg_wr
                                && memwb_rd != '0 && store_data == memwb_wdata))
      else $error("store forward without a valid write-back source");
    a_r2_store_carried: assert (store_sel || store_data == exmem_store_data)
      else $error("store data not the carried value");
    a_r3_no_load_fwd: assert (fwd_a_sel != 2'b10 || (!exmem_mem_rd && exmem_rd != '0
                              && exmem_rd == idex_rs1 && ex_opa == exmem_alu))
      else $error("bad memory-stage forward");
    a_r6_legal_sel: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
      else $error("illegal operand select");
    a_r6_rf_value: assert (fwd_a_sel != 2'b00 || ex_opa == idex_rs1_val)
      else $error("register-file operand mismatch");
    a_r7_stall_needs_load: assert (!stall || (idex_mem_rd && idex_rd != '0))
      else $error("stall without a load in execute");
    a_r9_hold_front: assert ((stall && !pc_wr_en && !ifid_wr_en && idex_bubble)
                             || (!stall && pc_wr_en && ifid_wr_en && !idex_bubble))
      else $error("stall controls disagree");
  end
endmodule

bind ldst_fwd_ctrl ldst_fwd_ctrl_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .idex_rs1(idex_rs1), .idex_rd(idex_rd), .idex_mem_rd(idex_mem_rd),
  .idex_rs1_val(idex_rs1_val), .exmem_rd(exmem_rd), .exmem_mem_rd(exmem_mem_rd),
  .exmem_mem_wr(exmem_mem_wr), .exmem_alu(exmem_alu),
  .exmem_store_data(exmem_store_data), .memwb_rd(memwb_rd),
  .memwb_reg_wr(memwb_reg_wr), .memwb_wdata(memwb_wdata),
  .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .ex_opa(ex_opa),
  .store_sel(store_sel), .store_data(store_data), .stall(stall),
  .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .idex_bubble(idex_bubble)
);

// File: tb/ldst_fwd_ctrl_bench.sv
module ldst_fwd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rd;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          reg_wr;
    logic          mem_rd;
    logic          mem_wr;
    logic          rs1_alu;
    logic          rs2_alu;
  } instr_t;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] idex_rs1, idex_rs2, idex_rd, exmem_rd, exmem_rs2, memwb_rd;
  logic [AW-1:0] ifid_rs1, ifid_rs2;
  logic idex_mem_rd, exmem_reg_wr, exmem_mem_rd, exmem_mem_wr, memwb_reg_wr;
  logic ifid_rs1_alu, ifid_rs2_alu;
  logic [DW-1:0] idex_rs1_val, idex_rs2_val, exmem_alu, exmem_store_data, memwb_wdata;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic [DW-1:0] ex_opa, ex_opb, store_data;
  logic store_sel, stall, pc_wr_en, ifid_wr_en, idex_bubble;

  ldst_fwd_ctrl #(.REG_AW(AW), .DATA_W(DW)) u_ldst_fwd_ctrl (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wb_tag(input logic [AW-1:0] r);
    return 32'h0000_1000 + DW'(r);
  endfunction
  function automatic logic [DW-1:0] alu_tag(input logic [AW-1:0] r);
    return 32'h0000_2000 + DW'(r);
  endfunction
  function automatic logic [DW-1:0] rf_tag(input logic [AW-1:0] r);
    return 32'h0000_3000 + DW'(r);
  endfunction
  function automatic logic [DW-1:0] carry_tag(input logic [AW-1:0] r);
    return 32'hDEAD_0000 + DW'(r);
  endfunction

  function automatic instr_t ld(input int rd, input int base);
    instr_t i = '0;
    i.valid = 1; i.rd = AW'(rd); i.rs1 = AW'(base); i.reg_wr = 1; i.mem_rd = 1; i.rs1_alu = 1;
    return i;
  endfunction
  function automatic instr_t st(input int src, input int base);
    instr_t i = '0;
    i.valid = 1; i.rs1 = AW'(base); i.rs2 = AW'(src); i.mem_wr = 1; i.rs1_alu = 1;
    return i;
  endfunction
  function automatic instr_t alu(input int rd, input int a, input int b);
    instr_t i = '0;
    i.valid = 1; i.rd = AW'(rd); i.rs1 = AW'(a); i.rs2 = AW'(b); i.reg_wr = 1;
    i.rs1_alu = 1; i.rs2_alu = 1;
    return i;
  endfunction

  instr_t prog [8];
  int     prog_len;

  task automatic drive_stages(input instr_t f, input instr_t d, input instr_t m, input instr_t w);
    ifid_rs1 = f.rs1; ifid_rs2 = f.rs2;
    ifid_rs1_alu = f.valid & f.rs1_alu; ifid_rs2_alu = f.valid & f.rs2_alu;
    idex_rs1 = d.rs1; idex_rs2 = d.rs2; idex_rd = d.rd; idex_mem_rd = d.mem_rd;
    idex_rs1_val = rf_tag(d.rs1); idex_rs2_val = rf_tag(d.rs2);
    exmem_rd = m.rd; exmem_reg_wr = m.reg_wr; exmem_mem_rd = m.mem_rd;
    exmem_mem_wr = m.mem_wr; exmem_rs2 = m.rs2;
    exmem_alu = alu_tag(m.rd); exmem_store_data = carry_tag(m.rs2);
    memwb_rd = w.rd; memwb_reg_wr = w.reg_wr; memwb_wdata = wb_tag(w.rd);
  endtask

  // Run prog through a four-register pipeline model; return stalls and store forwards.
  task automatic run_prog(input string req, output int stalls, output int fwds);
    instr_t f, d, m, w;
    int pc = 0;
    f = '0; d = '0; m = '0; w = '0;
    stalls = 0; fwds = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (pc < prog_len && !f.valid) begin f = prog[pc]; pc++; end
      @(negedge clk);
      drive_stages(f, d, m, w);
      #1;
      if (m.valid && m.mem_wr) begin
        logic exp_sel;
        exp_sel = w.reg_wr && (w.rd != '0) && (w.rd == m.rs2);
        chk(store_sel == exp_sel, {req, " R1/R2 store select"}, DW'(store_sel), DW'(exp_sel));
        chk(store_data == (exp_sel ? wb_tag(w.rd) : carry_tag(m.rs2)),
            {req, " R1/R2 store data"}, store_data,
            exp_sel ? wb_tag(w.rd) : carry_tag(m.rs2));
        if (store_sel) fwds++;
      end
      if (stall) begin
        stalls++;
        chk(!pc_wr_en && !ifid_wr_en && idex_bubble, {req, " R9 hold on stall"},
            DW'({pc_wr_en, ifid_wr_en, idex_bubble}), DW'(3'b001));
        w = m; m = d; d = '0;
      end else begin
        w = m; m = d; d = f; f = '0;
      end
      if (pc >= prog_len && !f.valid && !d.valid && !m.valid && !w.valid) break;
    end
  endtask

  task automatic t_idle;
    drive_stages('0, '0, '0, '0);
    #1;
    chk(fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00, "R6 idle selects",
        DW'({fwd_a_sel, fwd_b_sel}), 0);
    chk(!store_sel && !stall && pc_wr_en && ifid_wr_en && !idex_bubble, "R9 idle controls",
        DW'({store_sel, stall, pc_wr_en, ifid_wr_en, idex_bubble}), DW'(5'b00110));
  endtask

  task automatic t_copy;
    int s, fw;
    prog[0] = ld(4, 29); prog[1] = st(4, 16);
    prog[2] = ld(2, 29); prog[3] = st(2, 16);
    prog[4] = ld(6, 29); prog[5] = st(6, 16);
    prog_len = 6;
    run_prog("copy", s, fw);
    chk(s == 0, "R8 copy sequence stall-free", DW'(s), 0);
    chk(fw == 3, "R1 copy uses three store forwards", DW'(fw), 3);
  endtask

  task automatic t_load_use;
    int s, fw;
    prog[0] = ld(9, 29); prog[1] = alu(10, 9, 3); prog_len = 2;
    run_prog("load-use", s, fw);
    chk(s == 1, "R7 load then ALU use stalls once", DW'(s), 1);
  endtask

  task automatic t_reordered;
    int s, fw;
    prog[0] = ld(9, 29); prog[1] = ld(3, 29); prog[2] = alu(10, 9, 11); prog_len = 3;
    run_prog("reordered", s, fw);
    chk(s == 0, "R7 reordered sequence no stall", DW'(s), 0);
  endtask

  task automatic t_zero_reg;
    int s, fw;
    prog[0] = ld(0, 29); prog[1] = st(0, 16); prog[2] = ld(0, 29); prog[3] = alu(5, 0, 0);
    prog_len = 4;
    run_prog("zero", s, fw);
    chk(s == 0, "R10 load to register 0 never stalls", DW'(s), 0);
    chk(fw == 0, "R2 register 0 never forwards to store", DW'(fw), 0);
  endtask

  task automatic t_ex_fwd;
    @(negedge clk);
    // both stages write r7 -> memory stage wins
    drive_stages('0, alu(1, 7, 8), alu(7, 1, 1), alu(7, 2, 2));
    #1;
    chk(fwd_a_sel == 2'b10 && ex_opa == alu_tag(7), "R5 memory stage beats write-back",
        ex_opa, alu_tag(7));
    chk(fwd_b_sel == 2'b00 && ex_opb == rf_tag(8), "R6 unmatched operand from file",
        ex_opb, rf_tag(8));
    @(negedge clk);
    drive_stages('0, alu(1, 3, 8), alu(7, 1, 1), alu(8, 2, 2));
    #1;
    chk(fwd_b_sel == 2'b01 && ex_opb == wb_tag(8), "R4 write-back forward", ex_opb, wb_tag(8));
    @(negedge clk);
    drive_stages('0, alu(1, 7, 2), ld(7, 1), alu(7, 2, 2));
    #1;
    chk(fwd_a_sel == 2'b01 && ex_opa == wb_tag(7), "R3 load in memory stage not forwarded",
        ex_opa, wb_tag(7));
    @(negedge clk);
    drive_stages('0, alu(1, 0, 0), alu(0, 1, 1), alu(0, 2, 2));
    #1;
    chk(fwd_a_sel == 2'b00 && ex_opa == rf_tag(0), "R6 register 0 never forwards",
        ex_opa, rf_tag(0));
    @(negedge clk);
    drive_stages('0, alu(1, 31, 2), alu(31, 1, 1), '0);
    #1;
    chk(fwd_a_sel == 2'b10 && ex_opa == alu_tag(31), "R3 memory-stage forward r31",
        ex_opa, alu_tag(31));
  endtask

  task automatic t_store_only_use;
    @(negedge clk);
    drive_stages(st(5, 16), ld(5, 29), '0, '0);
    #1;
    chk(!stall, "R8 store-data use of load does not stall", DW'(stall), 0);
    @(negedge clk);
    drive_stages(st(16, 5), ld(5, 29), '0, '0);
    #1;
    chk(stall, "R7 load used as store base stalls", DW'(stall), 1);
  endtask

  initial begin
    drive_stages('0, '0, '0, '0);
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_idle();
    t_copy();
    t_load_use();
    t_reordered();
    t_zero_reg();
    t_ex_fwd();
    t_store_only_use();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule